// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block collects interrupt requests from many peripherals and folds them into a small set of group outputs. Source lines are arranged in nineteen groups of thirty-two. Each line latches into a sticky status bit that stays set until software clears it by writing a one. A per-bit enable mask selects which latched bits count towards the group. That mask has one address for setting bits and another for clearing them, so software never has to do a read-modify-write.

Each group drives one output. That output is high when any enabled latched bit in the group is set and the group's block-level enable bit is also set. The block-level enable map has its own set and clear addresses. A read-only map shows which group outputs are currently high. Groups are numbered 8 through 26: group N uses array index N-8, and bit N in the block-level maps.

Software reaches the block over a plain 32-bit register bus with byte addresses, one write strobe and one read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: While rst_n is low at a clock edge, every source bit, every enable bit and every block-enable bit is cleared. After reset, all group outputs are low and reads return zero.
- R2: A source bit is set at every clock edge where its input is high. It stays set after the input returns low.
- R3: Writing to the status word of a group clears each bit written as 1 and leaves bits written as 0 unchanged. If the input of a bit is high in the same cycle as a clearing write, the bit stays set.
- R4: Writing to the enable-set word sets each enable bit written as 1 and leaves the other bits unchanged. Reading either the enable-set word or the enable-clear word returns the current enable mask.
- R5: Writing to the enable-clear word clears each enable bit written as 1 and leaves the other bits unchanged.
- R6: Reading the result word returns the status bits ANDed with the enable bits. Writes to the result word have no effect.
- R7: The output of group N is high exactly when its result word is nonzero and bit N of the block-enable map is set. Bit 0 of grp_irq is group 8 and bit 18 is group 26.
- R8: A write to byte address 0x200 sets block-enable bits. A write to 0x204 clears them. In both cases bit N controls group N, and bits written as 0 are unchanged. Reading either address returns the block-enable map. Bits outside 8..26 read as 0.
- R9: Byte address 0x208 is read-only. Its bit N equals the current output of group N, and writes to it have no effect.
- R10: Reserved words read as zero and ignore writes. These are offset 0x10 of each group and any address that is not mapped.
- R11: bus_rdata is loaded at a clock edge where bus_rd is high, with the word at bus_addr. It holds its value at every other edge.
- R12: Group N starts at byte address (N-8)*0x14. Within a group, the words sit at these offsets: status 0x00, enable-set 0x04, result 0x08, enable-clear 0x0C, reserved 0x10. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 608 | Source lines; bits [32*i+31:32*i] belong to group i+8 |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| grp_irq | output | 19 | Aggregated group outputs, index 0 is group 8 |

## Verification
The assertions take for granted that source inputs are sampled as levels at the clock edge. They also assume that a status bit or enable bit can change only through a write or a high input, so they treat any other change as an error. They assume the bus never raises the write and read strobes for different addresses in the same cycle. The bench drives every input on the falling edge, raises at most one strobe per cycle, and holds source pulses for exactly one cycle. Each access therefore maps onto a single known edge, and so does the collision case where a clearing write and a source input meet.

// File: rtl/irq_agg_pkg.sv
// Package: shared register-kind encoding and address constants for the
// grouped interrupt aggregator. Assumes 32-bit word-aligned registers.
package irq_agg_pkg;
    localparam int BUS_DATA_W     = 32;
    localparam int GROUP_BYTES    = 'h14;
    localparam int GROUP_WORDS    = GROUP_BYTES / 4;
    localparam int BLK_BASE_BYTES = 'h200;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_STATUS  = 3'd1,
        KIND_EN_SET  = 3'd2,
        KIND_RESULT  = 3'd3,
        KIND_EN_CLR  = 3'd4,
        KIND_BLK_SET = 3'd5,
        KIND_BLK_CLR = 3'd6,
        KIND_BLK_ACT = 3'd7
    } reg_kind_e;
endpackage

// File: rtl/irq_addr_decode.sv
// Address decoder: turns a byte address into a register kind and a group
// index. Assumes the group array starts at byte 0 and the block map words
// sit at BLK_BASE, BLK_BASE+4 and BLK_BASE+8. Address bits 1:0 are ignored.
module irq_addr_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int NUM_GROUPS = 19,
    parameter int WPG        = GROUP_WORDS,
    parameter int BLK_BASE   = BLK_BASE_BYTES,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [GRP_W-1:0]  grp
);
    localparam int ARRAY_WORDS = NUM_GROUPS * WPG;
    localparam int BLK_WORD    = BLK_BASE / 4;

    logic [ADDR_W-3:0] word;
    assign word = addr[ADDR_W-1:2];

    // Split the word address into group number and offset inside the group.
    always_comb begin
        int grp_i;
        int off_i;
        grp_i = 0;
        off_i = 0;
        kind  = KIND_NONE;
        grp   = '0;
        if (int'(word) < ARRAY_WORDS) begin
            grp_i = int'(word) / WPG;
            off_i = int'(word) - grp_i * WPG;
            grp   = GRP_W'(grp_i);
            case (off_i)
                0:       kind = KIND_STATUS;
                1:       kind = KIND_EN_SET;
                2:       kind = KIND_RESULT;
                3:       kind = KIND_EN_CLR;
                default: kind = KIND_NONE;
            endcase
        end else if (int'(word) == BLK_WORD) begin
            kind = KIND_BLK_SET;
        end else if (int'(word) == BLK_WORD + 1) begin
            kind = KIND_BLK_CLR;
        end else if (int'(word) == BLK_WORD + 2) begin
            kind = KIND_BLK_ACT;
        end
    end
endmodule

// File: rtl/irq_group.sv
// One interrupt group. Holds the sticky status bits and the enable mask, and
// reports the masked result and whether any masked bit is set. Assumes that
// at most one of the three write strobes is high in any cycle. When an input
// is high in the same cycle as a clearing write, the input wins.
module irq_group #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_in,
    input  logic [SRC_W-1:0] wdata,
    input  logic             wr_status,
    input  logic             wr_en_set,
    input  logic             wr_en_clr,
    output logic [SRC_W-1:0] status_q,
    output logic [SRC_W-1:0] enable_q,
    output logic [SRC_W-1:0] result,
    output logic             any_hit
);
    logic [SRC_W-1:0] clr_mask;
    assign clr_mask = wr_status ? wdata : '0;

    // Latch source inputs; write-one clears, a new input overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | src_in;
    end

    // Enable mask update via the separate set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (wr_en_set) enable_q <= enable_q | wdata;
        else if (wr_en_clr) enable_q <= enable_q & ~wdata;
    end

    // Masked result and its reduction to one request.
    always_comb begin
        result  = status_q & enable_q;
        any_hit = |result;
    end
endmodule

// File: rtl/irq_block_ctrl.sv
// Block-level gate: holds one enable bit per group and gates each group's
// request with it. Places both the enable map and the active map at bit
// positions FIRST_GROUP..FIRST_GROUP+NUM_GROUPS-1 of a DATA_W-bit word.
// Assumes FIRST_GROUP + NUM_GROUPS <= DATA_W.
module irq_block_ctrl #(
    parameter int NUM_GROUPS  = 19,
    parameter int FIRST_GROUP = 8,
    parameter int DATA_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  wr_set,
    input  logic                  wr_clr,
    input  logic [NUM_GROUPS-1:0] grp_any,
    output logic [NUM_GROUPS-1:0] grp_irq,
    output logic [DATA_W-1:0]     en_map,
    output logic [DATA_W-1:0]     act_map
);
    logic [NUM_GROUPS-1:0] blk_en_q;
    logic [NUM_GROUPS-1:0] wsel;
    assign wsel = wdata[FIRST_GROUP +: NUM_GROUPS];

    // Block enable update via the set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_en_q <= '0;
        else if (wr_set) blk_en_q <= blk_en_q | wsel;
        else if (wr_clr) blk_en_q <= blk_en_q & ~wsel;
    end

    // Gate group requests and place both maps at their group bit positions.
    always_comb begin
        grp_irq = grp_any & blk_en_q;
        en_map  = DATA_W'(blk_en_q) << FIRST_GROUP;
        act_map = DATA_W'(grp_irq) << FIRST_GROUP;
    end
endmodule

// File: rtl/irq_aggregator.sv
// Top of the grouped interrupt aggregator. Decodes bus accesses, instantiates
// one irq_group per group, gates their requests at block level and registers
// the read data. Assumes one access per cycle and 32-bit aligned addresses.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_GROUPS  = 19,
    parameter int FIRST_GROUP = 8,
    parameter int SRC_W       = 32,
    parameter int ADDR_W      = 10,
    localparam int DATA_W     = BUS_DATA_W,
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*SRC_W-1:0] src_in,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_GROUPS-1:0]       grp_irq
);
    reg_kind_e         kind;
    logic [GRP_W-1:0]  grp;

    logic [SRC_W-1:0]  status_arr [NUM_GROUPS];
    logic [SRC_W-1:0]  enable_arr [NUM_GROUPS];
    logic [SRC_W-1:0]  result_arr [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]       grp_any;
    logic [NUM_GROUPS*SRC_W-1:0] status_all;
    logic [NUM_GROUPS*SRC_W-1:0] enable_all;
    logic [DATA_W-1:0] en_map;
    logic [DATA_W-1:0] act_map;
    logic [DATA_W-1:0] rd_word;

    irq_addr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .grp  (grp)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        logic hit;
        assign hit = (grp == GRP_W'(g));

        irq_group #(.SRC_W(SRC_W)) u_group (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_in    (src_in[g*SRC_W +: SRC_W]),
            .wdata     (bus_wdata[SRC_W-1:0]),
            .wr_status (bus_wr && hit && kind == KIND_STATUS),
            .wr_en_set (bus_wr && hit && kind == KIND_EN_SET),
            .wr_en_clr (bus_wr && hit && kind == KIND_EN_CLR),
            .status_q  (status_arr[g]),
            .enable_q  (enable_arr[g]),
            .result    (result_arr[g]),
            .any_hit   (grp_any[g])
        );

        assign status_all[g*SRC_W +: SRC_W] = status_arr[g];
        assign enable_all[g*SRC_W +: SRC_W] = enable_arr[g];
    end

    irq_block_ctrl #(
        .NUM_GROUPS  (NUM_GROUPS),
        .FIRST_GROUP (FIRST_GROUP),
        .DATA_W      (DATA_W)
    ) u_block (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdata   (bus_wdata),
        .wr_set  (bus_wr && kind == KIND_BLK_SET),
        .wr_clr  (bus_wr && kind == KIND_BLK_CLR),
        .grp_any (grp_any),
        .grp_irq (grp_irq),
        .en_map  (en_map),
        .act_map (act_map)
    );

    // Select the word addressed by the current access.
    always_comb begin
        rd_word = '0;
        case (kind)
            KIND_STATUS:               rd_word = DATA_W'(status_arr[grp]);
            KIND_EN_SET, KIND_EN_CLR:  rd_word = DATA_W'(enable_arr[grp]);
            KIND_RESULT:               rd_word = DATA_W'(result_arr[grp]);
            KIND_BLK_SET, KIND_BLK_CLR: rd_word = en_map;
            KIND_BLK_ACT:              rd_word = act_map;
            default:                   rd_word = '0;
        endcase
    end

    // Register read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Checker for irq_aggregator: temporal properties on the sticky status bits,
// the enable masks, the group outputs and the read data register.
module irq_aggregator_chk #(
    parameter int NUM_GROUPS = 19,
    parameter int SRC_W      = 32,
    parameter int DATA_W     = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_GROUPS*SRC_W-1:0] src_in,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_GROUPS*SRC_W-1:0] status_all,
    input logic [NUM_GROUPS*SRC_W-1:0] enable_all,
    input logic [NUM_GROUPS-1:0]       grp_irq
);
    // R2: every input seen high is latched at the next edge
    a_r2_input_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & $past(src_in)) == $past(src_in)));

    // R3: a status bit never rises without its input
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & ~$past(status_all) & ~$past(src_in)) == '0));

    // R3: a status bit falls only after a bus write
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((~status_all & $past(status_all)) == '0));

    // R4 / R5: enable masks change only after a bus write
    a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(enable_all));

    // R11: read data holds without a read strobe
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R7: a group output requires a latched bit in that group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
        a_r7_out_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> (|status_all[g*SRC_W +: SRC_W]));
    end
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .SRC_W      (SRC_W),
    .DATA_W     (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .status_all (status_all),
    .enable_all (enable_all),
    .grp_irq    (grp_irq)
);

// File: tb/test_irq_aggregator.sv
// Directed bench for irq_aggregator: one task per scenario, each checking
// its own results. Inputs change on the falling edge; results are sampled
// on the falling edge after the edge that updates them.
module test_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 19;
    localparam int SW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NG*SW-1:0] src_in = '0;
    logic [9:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    bus_rdata;
    logic [NG-1:0]  grp_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    irq_aggregator i_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .grp_irq   (grp_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R12: byte address of a word in group n
    function automatic logic [9:0] gaddr(int n, int off);
        return 10'((n - 8) * 'h14 + off);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_src(int n, logic [31:0] m);
        @(negedge clk);
        src_in[(n-8)*SW +: SW] = m;
        @(negedge clk);
        src_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 grp_irq after reset", 32'(grp_irq), 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(gaddr(8, 0), d);  check("R1 status g8", d, 32'h0);
        bus_read(gaddr(8, 4), d);  check("R1 enable g8", d, 32'h0);
        bus_read(10'h200, d);      check("R1 block enable", d, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse_src(10, 32'h5);
        repeat (2) @(negedge clk);
        bus_read(gaddr(10, 0), d); check("R2 sticky status g10", d, 32'h5);
        bus_read(gaddr(9, 0), d);  check("R12 neighbour g9 untouched", d, 32'h0);
    endtask

    task automatic t_enable_set();
        logic [31:0] d;
        bus_write(gaddr(10, 4), 32'h1);
        bus_write(gaddr(10, 4), 32'h0);
        bus_read(gaddr(10, 4), d);  check("R4 enable set, zero no effect", d, 32'h1);
        bus_read(gaddr(10, 'hC), d); check("R4 enable read via clear word", d, 32'h1);
        bus_read(gaddr(10, 8), d);  check("R6 result", d, 32'h1);
        check("R7 gated off by block enable", 32'(grp_irq), 32'h0);
        bus_write(10'h200, 32'h1 << 10);
        check("R7 group 10 output", 32'(grp_irq), 32'h4);
        bus_read(10'h208, d);       check("R9 active map", d, 32'h1 << 10);
        bus_read(10'h200, d);       check("R8 block enable read", d, 32'h1 << 10);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(gaddr(10, 0), 32'h0);
        bus_read(gaddr(10, 0), d);  check("R3 zero write no effect", d, 32'h5);
        bus_write(gaddr(10, 0), 32'h1);
        bus_read(gaddr(10, 0), d);  check("R3 write-one clear", d, 32'h4);
        bus_read(gaddr(10, 8), d);  check("R6 result after clear", d, 32'h0);
        check("R7 output drops", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk);
        src_in[(10-8)*SW +: SW] = 32'h4;
        bus_addr = gaddr(10, 0); bus_wdata = 32'h4; bus_wr = 1'b1;
        @(negedge clk);
        src_in = '0; bus_wr = 1'b0;
        bus_read(gaddr(10, 0), d);  check("R3 set wins over clear", d, 32'h4);
        bus_write(gaddr(10, 0), 32'h4);
        bus_read(gaddr(10, 0), d);  check("R3 clear without input", d, 32'h0);
    endtask

    task automatic t_enable_clr();
        logic [31:0] d;
        bus_write(gaddr(10, 4), 32'hF0);
        bus_write(gaddr(10, 'hC), 32'h0);
        bus_read(gaddr(10, 4), d);  check("R5 zero clear no effect", d, 32'hF1);
        bus_write(gaddr(10, 'hC), 32'h31);
        bus_read(gaddr(10, 4), d);  check("R5 clear bits", d, 32'hC0);
    endtask

    task automatic t_last_group();
        logic [31:0] d;
        pulse_src(26, 32'h8000_0000);
        bus_write(gaddr(26, 4), 32'h8000_0000);
        check("R7 no output before block enable", 32'(grp_irq), 32'h0);
        bus_write(10'h200, 32'h1 << 26);
        check("R7 group 26 on bit 18", 32'(grp_irq), 32'h1 << 18);
        bus_read(10'h208, d);       check("R9 active bit 26", d, 32'h1 << 26);
        bus_write(10'h204, 32'h1 << 26);
        check("R8 block clear", 32'(grp_irq), 32'h0);
        bus_read(10'h204, d);       check("R8 map via clear word", d, 32'h1 << 10);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_write(gaddr(26, 'h10), 32'hFFFF_FFFF);
        bus_read(gaddr(26, 'h10), d); check("R10 reserved reads zero", d, 32'h0);
        bus_read(10'h20C, d);       check("R10 unmapped reads zero", d, 32'h0);
        bus_write(gaddr(26, 8), 32'hFFFF_FFFF);
        bus_read(gaddr(26, 0), d);  check("R6 result write ignored", d, 32'h8000_0000);
        bus_write(10'h208, 32'hFFFF_FFFF);
        check("R9 active write ignored", 32'(grp_irq), 32'h0);
        bus_write(10'h200, 32'hFFFF_FFFF);
        bus_read(10'h200, d);       check("R8 only group bits", d, 32'h07FF_FF00);
        check("R7 group 26 back on", 32'(grp_irq), 32'h1 << 18);
        bus_write(10'h204, 32'hFFFF_FFFF);
        bus_read(10'h208, d);       check("R9 map after clear", d, 32'h0);
    endtask

    task automatic t_read_hold();
        logic [31:0] d;
        bus_read(gaddr(26, 4), d);
        repeat (3) @(negedge clk);
        check("R11 rdata holds", bus_rdata, 32'h8000_0000);
        bus_addr = 10'h20C;
        @(negedge clk);
        check("R11 no load without strobe", bus_rdata, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_enable_set();
        t_clear();
        t_collision();
        t_enable_clr();
        t_last_group();
        t_reserved();
        t_read_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule